// File: doc/BRIEF.md
# Dual-Channel Serial Control Front End

This block is the register-level control face of a two-channel asynchronous serial controller. A byte-wide bus reaches eight register slots per channel; the upper address bit picks the channel, so channel 1 sits eight locations above channel 0. Writes to a channel's command slot are turned into receiver and transmitter enable, disable and reset actions, error and break clearing, and break transmission control. A single mode slot reaches three format registers through a pointer that advances on every access. Command codes can reload the pointer.

The block drives character format, parity, stop-bit, FIFO depth and threshold selections to an external transmitter and receiver. It also builds each channel's status byte from FIFO level inputs, an idle input and receive error event pulses. The shifters, the FIFOs and the baud generator sit outside. The FIFOs are seen only through their fill levels and through push and pop strobes.

Top module: `ser_ctl_front`

## Requirements
- R1: Bus address bit 3 selects the channel and bits 2:0 the slot: 0 mode, 1 status (read) or clock select (write), 2 command (write), 3 receive holding (read) or transmit holding (write). An access to one channel leaves the other channel's state and outputs untouched. Reads of slots 2 and 4 to 7 return 0.
- R2: Command byte bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter and bit 3 disables it. If the enable and disable bits for one direction are both set, the direction ends up disabled. The new state is visible from the cycle after the write strobe.
- R3: Command code (bits 7:4) 2 raises `rx_reset` and code 3 raises `tx_reset`, combinationally, during the write cycle. Each reset leaves its direction disabled afterwards, even if the enable bit for that direction is set in the same byte.
- R4: After reset the mode pointer addresses MR0. Every read or write of slot 0 advances the pointer MR0→MR1→MR2, and the pointer then stays at MR2. Code 1 loads the pointer with MR1 and code 0xB loads it with MR0. Codes 2 and 3 leave the pointer unchanged. A read of slot 0 returns the register currently addressed.
- R5: `char_len` carries MR1[1:0] (0 = 5 bits through 3 = 8 bits). `parity_sel` carries MR1[4:2] (0 even, 1 odd, 4 none). `stop_two` is 1 exactly when MR2[3:0] is 0xF.
- R6: `fifo_deep` carries MR0[3], `tx_half_lvl` carries MR0[4] and `baud_ext` carries MR0[2:0].
- R7: Status bit 0 is set when the receive level is nonzero. Bit 1 is set when the receive level equals the active depth: DEEP_DEPTH (16) if MR0[3] is set, otherwise SHALLOW_DEPTH (3). Bit 2 is set when the transmitter is enabled and the transmit level is below the depth, or at most half the depth (rounded down) when MR0[4] is set. Bit 3 is set when the transmit level is 0 and `tx_idle` is high.
- R8: Status bits 4 to 7 are sticky copies of `err_evt` bits 0 to 3 of the channel: overrun, parity, framing and break. Code 4 clears bits 4 to 6 only. Code 5 clears bit 7 only. An event that arrives in the same cycle as a clear sets its bit.
- R9: Code 6 raises `break_tx` and code 7 drops it. Code 3 also drops it.
- R10: A write to slot 3 pulses `tx_push`, with `tx_data` equal to the written byte, only while the transmitter is enabled; otherwise the write is ignored. A read of slot 3 pulses `rx_pop` and returns the channel's `rx_hold` byte.
- R11: A write to slot 1 stores the byte and drives it on the channel's `clk_sel`.
- R12: After reset, the enables, break, sticky bits, mode registers and clock select are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Channel (bit 3) and slot (bits 2:0) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the read cycle |
| rx_level | input | 2×5 | Receive FIFO fill level per channel |
| tx_level | input | 2×5 | Transmit FIFO fill level per channel |
| tx_idle | input | 2 | Transmit shifter idle per channel |
| err_evt | input | 2×4 | Error event pulses per channel: overrun, parity, framing, break |
| rx_hold | input | 2×8 | Head byte of each receive FIFO |
| rx_enable | output | 2 | Receiver enabled |
| tx_enable | output | 2 | Transmitter enabled |
| rx_reset | output | 2 | Receiver reset pulse |
| tx_reset | output | 2 | Transmitter reset pulse |
| break_tx | output | 2 | Send break |
| tx_push | output | 2 | Transmit FIFO push strobe |
| rx_pop | output | 2 | Receive FIFO pop strobe |
| tx_data | output | 8 | Byte for the transmit FIFO |
| char_len | output | 2×2 | Character length code |
| parity_sel | output | 2×3 | Parity code |
| stop_two | output | 2 | Two stop bits |
| fifo_deep | output | 2 | Deep FIFO selected |
| tx_half_lvl | output | 2 | Half-level transmit-ready threshold |
| baud_ext | output | 2×3 | Extended baud table select |
| clk_sel | output | 2×8 | Clock select byte |

## Verification
The strobes `rx_reset`, `tx_reset`, `tx_push` and `rx_pop`, and the read data, are combinational in the access cycle. The bench samples them 1 ns after it drives the access, before the clock edge. Enables, break, pointer, mode fields, clock select and sticky status change at the edge that ends the access. The bench checks them at the following falling edge, or through a later status or mode read. Status bits 0 to 3 follow the level and idle inputs with no delay, so the bench sets those inputs one cycle before the read that checks them.

// File: rtl/ser_ctl_pkg.sv
`timescale 1ns/1ps
package ser_ctl_pkg;

  typedef enum logic [1:0] {
    PTR_MR0 = 2'd0,
    PTR_MR1 = 2'd1,
    PTR_MR2 = 2'd2
  } mr_ptr_e;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CMD  = 3'd2;
  localparam logic [2:0] OFS_HOLD = 3'd3;

  localparam logic [3:0] CODE_PTR_MR1 = 4'h1;
  localparam logic [3:0] CODE_RX_RST  = 4'h2;
  localparam logic [3:0] CODE_TX_RST  = 4'h3;
  localparam logic [3:0] CODE_ERR_CLR = 4'h4;
  localparam logic [3:0] CODE_BRK_CLR = 4'h5;
  localparam logic [3:0] CODE_BRK_ON  = 4'h6;
  localparam logic [3:0] CODE_BRK_OFF = 4'h7;
  localparam logic [3:0] CODE_PTR_MR0 = 4'hB;

  typedef struct packed {
    logic [3:0] code;
    logic       tx_off;
    logic       tx_on;
    logic       rx_off;
    logic       rx_on;
  } cmd_byte_t;

  function automatic mr_ptr_e ptr_step(mr_ptr_e p);
    case (p)
      PTR_MR0: return PTR_MR1;
      default: return PTR_MR2;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(int rx_lvl, int tx_lvl, int depth,
                                             logic half, logic tx_en, logic idle,
                                             logic [3:0] sticky);
    logic [7:0] s;
    s[0]   = (rx_lvl != 0);
    s[1]   = (rx_lvl == depth);
    s[2]   = tx_en && (half ? (tx_lvl <= depth / 2) : (tx_lvl < depth));
    s[3]   = (tx_lvl == 0) && idle;
    s[7:4] = sticky;
    return s;
  endfunction

endpackage

// File: rtl/ser_ctl_cmd.sv
`timescale 1ns/1ps
module ser_ctl_cmd
  import ser_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_data,
  input  logic [3:0] err_evt,
  output logic       rx_en,
  output logic       tx_en,
  output logic       brk_on,
  output logic       rx_rst,
  output logic       tx_rst,
  output logic       set_mr0,
  output logic       set_mr1,
  output logic [3:0] sticky
);

  cmd_byte_t  f;
  logic       err_clr, brk_clr, brk_start, brk_stop;
  logic       rx_drop, tx_drop;
  logic [3:0] sticky_d;

  assign f         = cmd_data;
  assign rx_rst    = cmd_we && (f.code == CODE_RX_RST);
  assign tx_rst    = cmd_we && (f.code == CODE_TX_RST);
  assign err_clr   = cmd_we && (f.code == CODE_ERR_CLR);
  assign brk_clr   = cmd_we && (f.code == CODE_BRK_CLR);
  assign brk_start = cmd_we && (f.code == CODE_BRK_ON);
  assign brk_stop  = cmd_we && (f.code == CODE_BRK_OFF);
  assign set_mr1   = cmd_we && (f.code == CODE_PTR_MR1);
  assign set_mr0   = cmd_we && (f.code == CODE_PTR_MR0);

  assign rx_drop = rx_rst || (cmd_we && f.rx_off);
  assign tx_drop = tx_rst || (cmd_we && f.tx_off);

  always_comb begin
    sticky_d = sticky;
    if (err_clr) sticky_d[2:0] = 3'b000;
    if (brk_clr) sticky_d[3]   = 1'b0;
    sticky_d = sticky_d | err_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
      brk_on <= 1'b0;
      sticky <= 4'h0;
    end else begin
      if (rx_drop)                rx_en <= 1'b0;
      else if (cmd_we && f.rx_on) rx_en <= 1'b1;
      if (tx_drop)                tx_en <= 1'b0;
      else if (cmd_we && f.tx_on) tx_en <= 1'b1;
      if (tx_rst || brk_stop)     brk_on <= 1'b0;
      else if (brk_start)         brk_on <= 1'b1;
      sticky <= sticky_d;
    end
  end

endmodule

// File: rtl/ser_ctl_mode.sv
`timescale 1ns/1ps
module ser_ctl_mode
  import ser_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_we,
  input  logic       mode_re,
  input  logic       csr_we,
  input  logic       set_mr0,
  input  logic       set_mr1,
  input  logic [7:0] wdata,
  output logic [7:0] mr0,
  output logic [7:0] mr1,
  output logic [7:0] mr2,
  output logic [7:0] csr,
  output logic [7:0] mode_rdata,
  output mr_ptr_e    ptr
);

  always_comb begin
    case (ptr)
      PTR_MR0: mode_rdata = mr0;
      PTR_MR1: mode_rdata = mr1;
      default: mode_rdata = mr2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= PTR_MR0;
      mr0 <= 8'h00;
      mr1 <= 8'h00;
      mr2 <= 8'h00;
      csr <= 8'h00;
    end else begin
      if (set_mr0)                 ptr <= PTR_MR0;
      else if (set_mr1)            ptr <= PTR_MR1;
      else if (mode_we || mode_re) ptr <= ptr_step(ptr);
      if (mode_we) begin
        case (ptr)
          PTR_MR0: mr0 <= wdata;
          PTR_MR1: mr1 <= wdata;
          default: mr2 <= wdata;
        endcase
      end
      if (csr_we) csr <= wdata;
    end
  end

endmodule

// File: rtl/ser_ctl_chan.sv
`timescale 1ns/1ps
module ser_ctl_chan
  import ser_ctl_pkg::*;
#(
  parameter int SHALLOW_DEPTH = 3,
  parameter int DEEP_DEPTH    = 16,
  parameter int LVL_W         = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_wr,
  input  logic             acc_rd,
  input  logic [2:0]       acc_ofs,
  input  logic [7:0]       wdata,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             tx_idle,
  input  logic [3:0]       err_evt,
  input  logic [7:0]       rx_hold,
  output logic [7:0]       rdata,
  output logic             rx_en,
  output logic             tx_en,
  output logic             rx_rst,
  output logic             tx_rst,
  output logic             brk_on,
  output logic             tx_push,
  output logic             rx_pop,
  output logic [1:0]       char_len,
  output logic [2:0]       parity_sel,
  output logic             stop_two,
  output logic             fifo_deep,
  output logic             tx_half,
  output logic [2:0]       baud_ext,
  output logic [7:0]       clk_sel,
  output logic [7:0]       status,
  output logic [1:0]       ptr_o
);

  logic       cmd_we, mode_we, mode_re, csr_we;
  logic       set_mr0, set_mr1;
  logic [3:0] sticky;
  logic [7:0] mr0, mr1, mr2, mode_rdata;
  mr_ptr_e    ptr;
  int         depth;

  assign cmd_we  = acc_wr && (acc_ofs == OFS_CMD);
  assign mode_we = acc_wr && (acc_ofs == OFS_MODE);
  assign mode_re = acc_rd && (acc_ofs == OFS_MODE);
  assign csr_we  = acc_wr && (acc_ofs == OFS_STAT);

  ser_ctl_cmd u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_we  (cmd_we),
    .cmd_data(wdata),
    .err_evt (err_evt),
    .rx_en   (rx_en),
    .tx_en   (tx_en),
    .brk_on  (brk_on),
    .rx_rst  (rx_rst),
    .tx_rst  (tx_rst),
    .set_mr0 (set_mr0),
    .set_mr1 (set_mr1),
    .sticky  (sticky)
  );

  ser_ctl_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_we   (mode_we),
    .mode_re   (mode_re),
    .csr_we    (csr_we),
    .set_mr0   (set_mr0),
    .set_mr1   (set_mr1),
    .wdata     (wdata),
    .mr0       (mr0),
    .mr1       (mr1),
    .mr2       (mr2),
    .csr       (clk_sel),
    .mode_rdata(mode_rdata),
    .ptr       (ptr)
  );

  assign ptr_o      = ptr;
  assign char_len   = mr1[1:0];
  assign parity_sel = mr1[4:2];
  assign stop_two   = (mr2[3:0] == 4'hF);
  assign fifo_deep  = mr0[3];
  assign tx_half    = mr0[4];
  assign baud_ext   = mr0[2:0];

  assign tx_push = acc_wr && (acc_ofs == OFS_HOLD) && tx_en;
  assign rx_pop  = acc_rd && (acc_ofs == OFS_HOLD);

  always_comb begin
    depth  = fifo_deep ? DEEP_DEPTH : SHALLOW_DEPTH;
    status = status_byte(int'(rx_level), int'(tx_level), depth, tx_half, tx_en,
                         tx_idle, sticky);
  end

  always_comb begin
    rdata = 8'h00;
    if (acc_rd) begin
      case (acc_ofs)
        OFS_MODE: rdata = mode_rdata;
        OFS_STAT: rdata = status;
        OFS_HOLD: rdata = rx_hold;
        default:  rdata = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/ser_ctl_front.sv
`timescale 1ns/1ps
module ser_ctl_front #(
  parameter  int NCH           = 2,
  parameter  int SHALLOW_DEPTH = 3,
  parameter  int DEEP_DEPTH    = 16,
  localparam int LVL_W         = $clog2(DEEP_DEPTH + 1),
  localparam int CH_W          = $clog2(NCH),
  localparam int AW            = CH_W + 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [AW-1:0]      bus_addr,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NCH*LVL_W-1:0] rx_level,
  input  logic [NCH*LVL_W-1:0] tx_level,
  input  logic [NCH-1:0]     tx_idle,
  input  logic [NCH*4-1:0]   err_evt,
  input  logic [NCH*8-1:0]   rx_hold,
  output logic [NCH-1:0]     rx_enable,
  output logic [NCH-1:0]     tx_enable,
  output logic [NCH-1:0]     rx_reset,
  output logic [NCH-1:0]     tx_reset,
  output logic [NCH-1:0]     break_tx,
  output logic [NCH-1:0]     tx_push,
  output logic [NCH-1:0]     rx_pop,
  output logic [7:0]         tx_data,
  output logic [NCH*2-1:0]   char_len,
  output logic [NCH*3-1:0]   parity_sel,
  output logic [NCH-1:0]     stop_two,
  output logic [NCH-1:0]     fifo_deep,
  output logic [NCH-1:0]     tx_half_lvl,
  output logic [NCH*3-1:0]   baud_ext,
  output logic [NCH*8-1:0]   clk_sel
);

  logic [NCH*8-1:0] chan_rdata;
  logic [NCH*8-1:0] chan_status;
  logic [NCH*2-1:0] chan_ptr;

  assign tx_data = bus_wdata;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit;
    assign hit = (bus_addr[AW-1:3] == CH_W'(g));

    ser_ctl_chan #(
      .SHALLOW_DEPTH(SHALLOW_DEPTH),
      .DEEP_DEPTH   (DEEP_DEPTH),
      .LVL_W        (LVL_W)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_wr    (bus_wr && hit),
      .acc_rd    (bus_rd && hit),
      .acc_ofs   (bus_addr[2:0]),
      .wdata     (bus_wdata),
      .rx_level  (rx_level[g*LVL_W +: LVL_W]),
      .tx_level  (tx_level[g*LVL_W +: LVL_W]),
      .tx_idle   (tx_idle[g]),
      .err_evt   (err_evt[g*4 +: 4]),
      .rx_hold   (rx_hold[g*8 +: 8]),
      .rdata     (chan_rdata[g*8 +: 8]),
      .rx_en     (rx_enable[g]),
      .tx_en     (tx_enable[g]),
      .rx_rst    (rx_reset[g]),
      .tx_rst    (tx_reset[g]),
      .brk_on    (break_tx[g]),
      .tx_push   (tx_push[g]),
      .rx_pop    (rx_pop[g]),
      .char_len  (char_len[g*2 +: 2]),
      .parity_sel(parity_sel[g*3 +: 3]),
      .stop_two  (stop_two[g]),
      .fifo_deep (fifo_deep[g]),
      .tx_half   (tx_half_lvl[g]),
      .baud_ext  (baud_ext[g*3 +: 3]),
      .clk_sel   (clk_sel[g*8 +: 8]),
      .status    (chan_status[g*8 +: 8]),
      .ptr_o     (chan_ptr[g*2 +: 2])
    );
  end

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NCH; i++) bus_rdata = bus_rdata | chan_rdata[i*8 +: 8];
  end

endmodule

// File: rtl/ser_ctl_chk.sv
`timescale 1ns/1ps
module ser_ctl_chk #(
  parameter int NCH  = 2,
  parameter int AW   = 4,
  parameter int CH_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [7:0]       bus_wdata,
  input logic [NCH-1:0]   rx_enable,
  input logic [NCH-1:0]   tx_enable,
  input logic [NCH-1:0]   rx_reset,
  input logic [NCH-1:0]   tx_reset,
  input logic [NCH-1:0]   break_tx,
  input logic [NCH-1:0]   tx_push,
  input logic [NCH-1:0]   rx_pop,
  input logic [NCH*8-1:0] chan_status,
  input logic [NCH*2-1:0] chan_ptr
);

  AST_ONE_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_push)); // R1
  AST_ONE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_pop)); // R1

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic cmd_hit;
    assign cmd_hit = bus_wr && (bus_addr == {CH_W'(g), 3'd2});

    AST_RX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && bus_wdata[1] |=> !rx_enable[g]); // R2
    AST_TX_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_hit && bus_wdata[3] |=> !tx_enable[g]); // R2
    AST_RX_RESET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      rx_reset[g] |=> !rx_enable[g]); // R3
    AST_TX_RESET_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset[g] |=> !tx_enable[g]); // R3
    AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      chan_ptr[g*2 +: 2] != 2'd3); // R4
    AST_PTR_HOLDS_MR2: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_ptr[g*2 +: 2] == 2'd2) &&
      !(cmd_hit && (bus_wdata[7:4] == 4'h1 || bus_wdata[7:4] == 4'hB))
      |=> chan_ptr[g*2 +: 2] == 2'd2); // R4
    AST_FULL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      chan_status[g*8+1] |-> chan_status[g*8]); // R7
    AST_BRK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      chan_status[g*8+7] && !(cmd_hit && bus_wdata[7:4] == 4'h5)
      |=> chan_status[g*8+7]); // R8
    AST_BRK_DROP_ON_TXRST: assert property (@(posedge clk) disable iff (!rst_n)
      tx_reset[g] |=> !break_tx[g]); // R9
    AST_PUSH_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push[g] |-> tx_enable[g]); // R10
  end

endmodule

bind ser_ctl_front ser_ctl_chk #(.NCH(NCH), .AW(AW), .CH_W(CH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rx_enable  (rx_enable),
  .tx_enable  (tx_enable),
  .rx_reset   (rx_reset),
  .tx_reset   (tx_reset),
  .break_tx   (break_tx),
  .tx_push    (tx_push),
  .rx_pop     (rx_pop),
  .chan_status(chan_status),
  .chan_ptr   (chan_ptr)
);

// File: tb/tb_ser_ctl_front.sv
`timescale 1ns/1ps
module tb_ser_ctl_front;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [4:0]  rxl [2];
  logic [4:0]  txl [2];
  logic [1:0]  tx_idle = 2'b11;
  logic [7:0]  err_evt = 8'h00;
  logic [15:0] rx_hold = 16'h0000;
  logic [1:0]  rx_enable, tx_enable, rx_reset, tx_reset, break_tx, tx_push, rx_pop;
  logic [7:0]  tx_data;
  logic [3:0]  char_len;
  logic [5:0]  parity_sel, baud_ext;
  logic [1:0]  stop_two, fifo_deep, tx_half_lvl;
  logic [15:0] clk_sel;

  always #5 clk = ~clk;

  ser_ctl_front dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_level({rxl[1], rxl[0]}), .tx_level({txl[1], txl[0]}), .tx_idle(tx_idle),
    .err_evt(err_evt), .rx_hold(rx_hold), .rx_enable(rx_enable), .tx_enable(tx_enable),
    .rx_reset(rx_reset), .tx_reset(tx_reset), .break_tx(break_tx), .tx_push(tx_push),
    .rx_pop(rx_pop), .tx_data(tx_data), .char_len(char_len), .parity_sel(parity_sel),
    .stop_two(stop_two), .fifo_deep(fifo_deep), .tx_half_lvl(tx_half_lvl),
    .baud_ext(baud_ext), .clk_sel(clk_sel)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit         m_rxen [2], m_txen [2], m_brk [2];
  int         m_ptr [2];
  logic [7:0] m_mr [2][3];
  logic [7:0] m_csr [2];
  logic [3:0] m_stk [2];

  // values captured inside the access cycle
  logic [1:0] c_rxrst, c_txrst, c_push, c_pop;
  logic [7:0] c_txdata, c_rdata;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int c, int ofs, logic [7:0] d);
    @(negedge clk);
    bus_addr = 4'(c * 8 + ofs); bus_wdata = d; bus_wr = 1'b1;
    #1;
    c_rxrst = rx_reset; c_txrst = tx_reset; c_push = tx_push; c_txdata = tx_data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int c, int ofs);
    @(negedge clk);
    bus_addr = 4'(c * 8 + ofs); bus_rd = 1'b1;
    #1;
    c_rdata = bus_rdata; c_pop = rx_pop;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic void model_cmd(int c, logic [7:0] d);
    logic [3:0] code = d[7:4];
    if (d[1] || code == 4'h2) m_rxen[c] = 0; else if (d[0]) m_rxen[c] = 1;
    if (d[3] || code == 4'h3) m_txen[c] = 0; else if (d[2]) m_txen[c] = 1;
    case (code)
      4'h1: m_ptr[c] = 1;
      4'hB: m_ptr[c] = 0;
      4'h3: m_brk[c] = 0;
      4'h4: m_stk[c] = m_stk[c] & 4'b1000;
      4'h5: m_stk[c] = m_stk[c] & 4'b0111;
      4'h6: m_brk[c] = 1;
      4'h7: m_brk[c] = 0;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] exp_status(int c);
    int depth = m_mr[c][0][3] ? 16 : 3;
    logic [7:0] s = {m_stk[c], 4'h0};
    if (rxl[c] != 0) s[0] = 1;
    if (int'(rxl[c]) >= depth) s[1] = 1;
    if (m_txen[c]) begin
      if (m_mr[c][0][4]) s[2] = (2 * int'(txl[c]) <= depth);
      else               s[2] = (int'(txl[c]) < depth);
    end
    if (txl[c] == 0 && tx_idle[c]) s[3] = 1;
    return s;
  endfunction

  task automatic do_cmd(int c, logic [7:0] d, string req);
    wr(c, 2, d);
    chk({req, " reset pulses"}, {c_txrst, c_rxrst},
        {2'(d[7:4] == 4'h3) << c, 2'(d[7:4] == 4'h2) << c});
    model_cmd(c, d);
  endtask

  task automatic mode_wr(int c, logic [7:0] d);
    wr(c, 0, d);
    m_mr[c][m_ptr[c]] = d;
    if (m_ptr[c] < 2) m_ptr[c]++;
  endtask

  task automatic mode_rd(int c, string req);
    rd(c, 0);
    chk(req, c_rdata, m_mr[c][m_ptr[c]]);
    if (m_ptr[c] < 2) m_ptr[c]++;
  endtask

  task automatic stat_rd(int c, string req);
    rd(c, 1);
    chk(req, c_rdata, exp_status(c));
  endtask

  task automatic check_outs(string req);
    for (int c = 0; c < 2; c++) begin
      chk({req, " R2 enables"}, {rx_enable[c], tx_enable[c]}, {m_rxen[c], m_txen[c]});
      chk({req, " R9 break"}, break_tx[c], m_brk[c]);
      chk({req, " R5 format"}, {char_len[c*2 +: 2], parity_sel[c*3 +: 3], stop_two[c]},
          {m_mr[c][1][1:0], m_mr[c][1][4:2], m_mr[c][2][3:0] == 4'hF});
      chk({req, " R6 mr0 fields"}, {fifo_deep[c], tx_half_lvl[c], baud_ext[c*3 +: 3]},
          {m_mr[c][0][3], m_mr[c][0][4], m_mr[c][0][2:0]});
      chk({req, " R11 clock select"}, clk_sel[c*8 +: 8], m_csr[c]);
    end
  endtask

  task automatic pulse_evt(logic [7:0] e);
    @(negedge clk); err_evt = e;
    @(negedge clk); err_evt = 8'h00;
    m_stk[0] = m_stk[0] | e[3:0];
    m_stk[1] = m_stk[1] | e[7:4];
  endtask

  initial begin
    rxl[0] = 0; rxl[1] = 0; txl[0] = 0; txl[1] = 0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3:0] codes [10] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hB, 4'h9};
    void'($urandom(32'd4711));
    for (int c = 0; c < 2; c++) begin
      m_rxen[c] = 0; m_txen[c] = 0; m_brk[c] = 0; m_ptr[c] = 0;
      m_mr[c][0] = 0; m_mr[c][1] = 0; m_mr[c][2] = 0; m_csr[c] = 0; m_stk[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check_outs("R12 reset");
    stat_rd(0, "R12 reset status");
    chk("R12 status value", c_rdata, 8'h08);

    // R4 R5 R6: pointer walk from MR0
    mode_wr(0, 8'h1D); mode_wr(0, 8'h12); mode_wr(0, 8'h0F);
    chk("R5 two stop", stop_two[0], 1'b1);
    check_outs("R6 after mode load");
    mode_wr(0, 8'h07);
    chk("R4 held at MR2", stop_two[0], 1'b0);
    chk("R1 other channel format", {char_len[3:2], fifo_deep[1]}, 3'b000);
    do_cmd(0, 8'h10, "R4 ptr mr1");
    mode_rd(0, "R4 read MR1");
    mode_rd(0, "R4 read MR2");
    mode_rd(0, "R4 read MR2 again");
    do_cmd(0, 8'hB0, "R4 ptr mr0");
    mode_rd(0, "R4 read MR0");
    do_cmd(0, 8'h10, "R4 ptr mr1");
    do_cmd(0, 8'h20, "R4 rx reset");
    do_cmd(0, 8'h30, "R4 tx reset");
    mode_rd(0, "R4 pointer kept over resets");

    // R2 R3: enable/disable
    do_cmd(0, 8'h05, "R2 enable both");
    check_outs("R2 enabled");
    do_cmd(0, 8'h03, "R2 rx disable wins");
    chk("R2 rx disable wins", rx_enable[0], 1'b0);
    do_cmd(0, 8'h0C, "R2 tx disable wins");
    chk("R2 tx disable wins", tx_enable[0], 1'b0);
    do_cmd(0, 8'h25, "R3 rx reset with enables");
    chk("R3 rx reset pulse", c_rxrst, 2'b01);
    chk("R3 rx stays off", {rx_enable[0], tx_enable[0]}, 2'b01);

    // R9 break
    do_cmd(1, 8'h60, "R9 start break");
    chk("R9 break on", break_tx, 2'b10);
    do_cmd(1, 8'h70, "R9 stop break");
    chk("R9 break off", break_tx, 2'b00);
    do_cmd(1, 8'h64, "R9 start break");
    do_cmd(1, 8'h30, "R9 tx reset");
    chk("R9 tx reset drops break", {break_tx[1], tx_enable[1]}, 2'b00);

    // R8 sticky errors
    pulse_evt(8'hF0);
    stat_rd(1, "R8 all sticky set");
    do_cmd(1, 8'h40, "R8 err clear");
    stat_rd(1, "R8 only break left");
    chk("R8 upper nibble", c_rdata[7:4], 4'h8);
    do_cmd(1, 8'h50, "R8 break clear");
    stat_rd(1, "R8 all clear");
    pulse_evt(8'h20);
    @(negedge clk); bus_addr = 4'hA; bus_wdata = 8'h40; bus_wr = 1'b1; err_evt = 8'h10;
    @(negedge clk); bus_wr = 1'b0; err_evt = 8'h00;
    m_stk[1] = 4'h1;
    stat_rd(1, "R8 event beats clear");

    // R11 R1 clock select per channel
    wr(1, 1, 8'hAB); m_csr[1] = 8'hAB;
    check_outs("R11 R1 channel csr");

    // R10 holding registers
    wr(1, 3, 8'h5A);
    chk("R10 no push when disabled", c_push, 2'b00);
    do_cmd(1, 8'h04, "R10 tx enable");
    wr(1, 3, 8'hC3);
    chk("R10 push", {c_push, c_txdata}, {2'b10, 8'hC3});
    rx_hold = 16'h9E11;
    rd(1, 3);
    chk("R10 rx pop", {c_pop, c_rdata}, {2'b10, 8'h9E});
    rd(0, 2);
    chk("R1 command slot reads zero", c_rdata, 8'h00);

    // R7 status corners
    rxl[1] = 3; txl[1] = 2; tx_idle = 2'b00;
    stat_rd(1, "R7 shallow full");
    mode_wr(1, 8'h18);
    rxl[1] = 3; txl[1] = 8;
    stat_rd(1, "R7 deep half level ready");
    txl[1] = 9;
    stat_rd(1, "R7 deep half level not ready");
    rxl[1] = 16; txl[1] = 0; tx_idle = 2'b10;
    stat_rd(1, "R7 deep full empty");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int c = $urandom_range(0, 1);
      int op = $urandom_range(0, 6);
      case (op)
        0, 1: do_cmd(c, {codes[$urandom_range(0, 9)], 4'($urandom_range(0, 15))}, "R2 R3 random cmd");
        2: mode_wr(c, 8'($urandom));
        3: mode_rd(c, "R4 random mode read");
        4: begin
          int depth = m_mr[c][0][3] ? 16 : 3;
          rxl[c] = 5'($urandom_range(0, depth));
          txl[c] = 5'($urandom_range(0, depth));
          tx_idle = 2'($urandom);
          stat_rd(c, "R7 R8 random status");
        end
        5: begin
          logic [7:0] d = 8'($urandom);
          wr(c, 3, d);
          chk("R10 random push", {c_push, c_txdata},
              {2'(m_txen[c]) << c, d});
        end
        default: if ($urandom_range(0, 1) == 1) pulse_evt(8'($urandom));
                 else begin
                   logic [7:0] d = 8'($urandom);
                   wr(c, 1, d); m_csr[c] = d;
                 end
      endcase
      check_outs("R1 random outputs");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule